// File: doc/BRIEF.md
# Guarded DMA Destination Address Register

This block holds the destination address of one DMA channel. Software writes and reads it as a 32-bit register. Each time the channel wants to move one unit of data, it raises an advance strobe. The block then checks the current address before it lets that unit go. If the check passes, the block issues the unit at that address and steps the address by the unit size. If the check fails, it latches a shared address-error flag that halts every channel.

Only the low 29 bits form the transfer address. The check has two parts. The address must be aligned to the unit size. It must also avoid forbidden regions: the top area of the map is forbidden for external-bus targets, and within the on-chip peripheral space only a few fixed windows exist. In single-address mode, a destination selected by its acknowledge line needs no address, so the register is neither checked nor stepped for that unit.

The control is a three-state machine:
- `ST_READY`: idle, no error.
- `ST_ISSUE`: a unit was issued in the cycle just past.
- `ST_FAULT`: the error flag is set.

The transitions are:
- READY or ISSUE to ISSUE: a strobe is accepted.
- READY or ISSUE to FAULT: a strobe is rejected.
- ISSUE to READY: no strobe arrives.
- FAULT to READY: software writes 0 to the flag.

Top module: `dst_addr_guard`

## Requirements
- R1: After reset, `reg_rd_data` is 0 and `halt_all` and `unit_issue` are 0.
- R2: `reg_wr_en` loads all 32 bits of `reg_wr_data`. The new value is visible on `reg_rd_data` in the next cycle. A strobe in the same cycle as a register write is dropped: no unit is issued and no check is made.
- R3: An accepted strobe raises `unit_issue` in the next cycle. In that cycle `issue_addr` holds bits 28:0 of the address used. The register's bits 28:0 then advance by the unit size: `xfer_size` 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes, 3 = 32 bytes. Bits 31:29 are unchanged.
- R4: Alignment is checked per unit size. Size 0 needs bit 0 clear. Size 1 needs bits 1:0 clear. Size 2 needs bits 2:0 clear. Size 3 needs bits 4:0 clear. Any other address is an error.
- R5: On an error, `halt_all` is 1 in the next cycle. No unit is issued and the register keeps its value.
- R6: With `ext_bus` = 1, an address whose bits 28:26 are 3'b111 is an error.
- R7: With `ext_bus` = 0, an address whose bits 28:24 are 5'b11111 is an error unless bits 23:16 fall in one of these windows: 0x00–0x0F, 0x20–0x27, 0x80, or 0xC0–0xC3. No other address is a region error when `ext_bus` = 0.
- R8: Bits 31:29 take no part in any check.
- R9: When `sa_mode` and `dst_ack_dev` are both 1, a strobe issues the unit without any check. `issue_addr` is the register's bits 28:0, and the register is not stepped.
- R10: While `halt_all` is 1, strobes are ignored. No unit is issued and the register does not move.
- R11: While halted, a flag write (`flag_wr_en`) with `flag_wr_data` = 0 clears `halt_all` in the next cycle. A flag write with data 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_data | output | 32 | Current register value |
| flag_wr_en | input | 1 | Write strobe for the error flag |
| flag_wr_data | input | 1 | Flag write value (0 clears) |
| xfer_size | input | 2 | Unit size code |
| adv_strb | input | 1 | Request to issue one unit |
| sa_mode | input | 1 | Single-address mode |
| dst_ack_dev | input | 1 | Destination is an acknowledge-selected device |
| ext_bus | input | 1 | Unit travels over the external bus |
| halt_all | output | 1 | Shared address-error flag; halts all channels |
| unit_issue | output | 1 | One unit issued |
| issue_addr | output | 29 | Address of the issued unit |

## Verification
Every result is due one edge after the stimulus that causes it. A strobe sampled at one rising edge shows its effect at that same edge: `unit_issue`, `issue_addr`, the stepped `reg_rd_data` and `halt_all` all change together. A register write or flag clear likewise shows one edge later.

The bench drives inputs just after a falling edge. A behavioural model updates at each rising edge. Every output is compared against the model at the following falling edge, so each result is checked in exactly the cycle it is due. Directed checks sample at that same falling edge after each stimulus.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [1:0] {
        SZ_2B  = 2'd0,
        SZ_4B  = 2'd1,
        SZ_8B  = 2'd2,
        SZ_32B = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FAULT = 2'd2
    } guard_state_e;

    localparam int NUM_WIN = 4;

    function automatic int size_shift(xfer_size_e sz);
        unique case (sz)
            SZ_2B:   return 1;
            SZ_4B:   return 2;
            SZ_8B:   return 3;
            default: return 5;
        endcase
    endfunction

    function automatic logic [7:0] win_lo(int i);
        case (i)
            0:       return 8'h00;
            1:       return 8'h20;
            2:       return 8'h80;
            default: return 8'hC0;
        endcase
    endfunction

    function automatic logic [7:0] win_hi(int i);
        case (i)
            0:       return 8'h0F;
            1:       return 8'h27;
            2:       return 8'h80;
            default: return 8'hC3;
        endcase
    endfunction

endpackage

// File: rtl/dag_align_chk.sv
module dag_align_chk
    import dag_pkg::*;
(
    input  logic [4:0]  low_bits,
    input  xfer_size_e  size,
    output logic        misaligned
);
    logic [4:0] mask;

    always_comb begin
        mask       = 5'((32'd1 << size_shift(size)) - 32'd1);
        misaligned = |(low_bits & mask);
    end
endmodule

// File: rtl/dag_region_chk.sv
module dag_region_chk
    import dag_pkg::*;
#(
    parameter int PHYS_W = 29,
    localparam int HI_W  = PHYS_W - 16
) (
    input  logic [HI_W-1:0] addr_hi,
    input  logic            ext_bus,
    output logic            area7_hit,
    output logic            perif_bad
);
    logic [7:0]         blk_idx;
    logic [NUM_WIN-1:0] win_hit;
    logic               perif_space;

    assign blk_idx = addr_hi[7:0];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            assign win_hit[gi] = (blk_idx >= win_lo(gi)) && (blk_idx <= win_hi(gi));
        end
    endgenerate

    always_comb begin
        perif_space = (addr_hi[HI_W-1 -: 5] == 5'h1F);
        area7_hit   = ext_bus && (addr_hi[HI_W-1 -: 3] == 3'b111);
        perif_bad   = !ext_bus && perif_space && !(|win_hit);
    end
endmodule

// File: rtl/dst_addr_guard.sv
module dst_addr_guard
    import dag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PHYS_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_data,
    output logic [ADDR_W-1:0] reg_rd_data,
    input  logic              flag_wr_en,
    input  logic              flag_wr_data,
    input  logic [1:0]        xfer_size,
    input  logic              adv_strb,
    input  logic              sa_mode,
    input  logic              dst_ack_dev,
    input  logic              ext_bus,
    output logic              halt_all,
    output logic              unit_issue,
    output logic [PHYS_W-1:0] issue_addr
);
    guard_state_e      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [PHYS_W-1:0] iaddr_q;
    logic [PHYS_W-1:0] phys;
    logic [PHYS_W-1:0] step;
    xfer_size_e        sz;
    logic misaligned, area7_hit, perif_bad;
    logic bypass, halted, take, bad, accept, reject, flag_clear;

    assign sz   = xfer_size_e'(xfer_size);
    assign phys = addr_q[PHYS_W-1:0];

    dag_align_chk u_align (
        .low_bits   (phys[4:0]),
        .size       (sz),
        .misaligned (misaligned)
    );

    dag_region_chk #(.PHYS_W(PHYS_W)) u_region (
        .addr_hi   (phys[PHYS_W-1:16]),
        .ext_bus   (ext_bus),
        .area7_hit (area7_hit),
        .perif_bad (perif_bad)
    );

    always_comb begin
        step       = PHYS_W'(1) << size_shift(sz);
        bypass     = sa_mode && dst_ack_dev;
        halted     = (state_q == ST_FAULT);
        take       = adv_strb && !reg_wr_en && !halted;
        bad        = misaligned || area7_hit || perif_bad;
        accept     = take && (bypass || !bad);
        reject     = take && !bypass && bad;
        flag_clear = flag_wr_en && !flag_wr_data;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY, ST_ISSUE: begin
                if (reject)      state_d = ST_FAULT;
                else if (accept) state_d = ST_ISSUE;
                else             state_d = ST_READY;
            end
            ST_FAULT: begin
                if (flag_clear)  state_d = ST_READY;
            end
            default:             state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // address and issue-address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            iaddr_q <= '0;
        end else begin
            if (accept) iaddr_q <= phys;
            if (reg_wr_en)
                addr_q <= reg_wr_data;
            else if (accept && !bypass)
                addr_q[PHYS_W-1:0] <= phys + step;
        end
    end

    // outputs
    always_comb begin
        reg_rd_data = addr_q;
        issue_addr  = iaddr_q;
        unit_issue  = (state_q == ST_ISSUE);
        halt_all    = (state_q == ST_FAULT);
    end

    // R5
    fault_on_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_strb && !reg_wr_en && !halt_all && !bypass && (misaligned || area7_hit || perif_bad))
        |=> (halt_all && !unit_issue));

    // R3
    issue_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (unit_issue && issue_addr == $past(reg_rd_data[PHYS_W-1:0])));

    // R10
    halted_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_all && !reg_wr_en) |=> ($stable(reg_rd_data) && !unit_issue));

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_all && flag_wr_en && !flag_wr_data) |=> !halt_all);

    // R9
    bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bypass) |=> ($stable(reg_rd_data) && unit_issue && !halt_all));
endmodule

// File: tb/dst_addr_guard_tb.sv
`timescale 1ns/1ps
module dst_addr_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        flag_wr_en = 0, flag_wr_data = 0;
    logic [1:0]  xfer_size = '0;
    logic        adv_strb = 0, sa_mode = 0, dst_ack_dev = 0, ext_bus = 0;
    logic        halt_all, unit_issue;
    logic [28:0] issue_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_addr = '0;
    logic [28:0] m_iaddr = '0;
    bit          m_issue = 0, m_halt = 0;

    always #4 clk = ~clk;

    dst_addr_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .xfer_size(xfer_size), .adv_strb(adv_strb), .sa_mode(sa_mode),
        .dst_ack_dev(dst_ack_dev), .ext_bus(ext_bus),
        .halt_all(halt_all), .unit_issue(unit_issue), .issue_addr(issue_addr)
    );

    function automatic bit addr_bad(logic [31:0] a, logic [1:0] sz, bit ext);
        int unsigned p, nbytes, idx;
        bit mis, a7, per;
        p      = a & 32'h1FFF_FFFF;
        nbytes = (sz == 0) ? 2 : (sz == 1) ? 4 : (sz == 2) ? 8 : 32;
        mis    = (p % nbytes) != 0;
        a7     = ext && ((p >> 26) == 7);
        idx    = (p >> 16) & 8'hFF;
        per    = !ext && ((p >> 24) == 31) &&
                 !(idx <= 15 || (idx >= 32 && idx <= 39) || idx == 128 ||
                   (idx >= 192 && idx <= 195));
        return mis || a7 || per;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = '0; m_iaddr = '0; m_issue = 0; m_halt = 0;
        end else begin
            bit take;
            int unsigned nbytes;
            take    = adv_strb && !reg_wr_en && !m_halt;
            m_issue = 0;
            nbytes  = (xfer_size == 0) ? 2 : (xfer_size == 1) ? 4 : (xfer_size == 2) ? 8 : 32;
            if (m_halt) begin
                if (flag_wr_en && !flag_wr_data) m_halt = 0;
            end else if (take) begin
                if (sa_mode && dst_ack_dev) begin
                    m_issue = 1; m_iaddr = m_addr[28:0];
                end else if (addr_bad(m_addr, xfer_size, ext_bus)) begin
                    m_halt = 1;
                end else begin
                    m_issue = 1; m_iaddr = m_addr[28:0];
                    m_addr[28:0] = m_addr[28:0] + 29'(nbytes);
                end
            end
            if (reg_wr_en) m_addr = reg_wr_data;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 reg_rd_data", reg_rd_data, m_addr);
            check("R5 halt_all", 32'(halt_all), 32'(m_halt));
            check("R3 unit_issue", 32'(unit_issue), 32'(m_issue));
            check("R3 issue_addr", 32'(issue_addr), 32'(m_iaddr));
        end
    end

    task automatic idle_inputs();
        reg_wr_en = 0; flag_wr_en = 0; flag_wr_data = 0; adv_strb = 0;
        sa_mode = 0; dst_ack_dev = 0; ext_bus = 0;
    endtask

    task automatic wr_reg(logic [31:0] v);
        @(negedge clk); idle_inputs(); reg_wr_en = 1; reg_wr_data = v;
        @(negedge clk); idle_inputs();
    endtask

    task automatic strobe(logic [1:0] sz, bit ext, bit sa, bit ack);
        @(negedge clk); idle_inputs();
        adv_strb = 1; xfer_size = sz; ext_bus = ext; sa_mode = sa; dst_ack_dev = ack;
        @(negedge clk); idle_inputs();
    endtask

    task automatic wr_flag(bit v);
        @(negedge clk); idle_inputs(); flag_wr_en = 1; flag_wr_data = v;
        @(negedge clk); idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 reset addr", reg_rd_data, 32'h0);
        check("R1 reset halt", 32'(halt_all), 32'h0);
        check("R1 reset issue", 32'(unit_issue), 32'h0);
        rst_n = 1;

        wr_reg(32'h0000_1000);
        check("R2 write", reg_rd_data, 32'h0000_1000);
        strobe(2'd1, 0, 0, 0);
        check("R3 issue", 32'(unit_issue), 32'h1);
        check("R3 issue_addr", 32'(issue_addr), 32'h1000);
        check("R3 step 4", reg_rd_data, 32'h0000_1004);

        strobe(2'd3, 0, 0, 0);
        check("R4 32B misaligned", 32'(halt_all), 32'h1);
        check("R5 addr held", reg_rd_data, 32'h0000_1004);
        check("R5 no issue", 32'(unit_issue), 32'h0);
        strobe(2'd1, 0, 0, 0);
        check("R10 halted strobe ignored", reg_rd_data, 32'h0000_1004);
        check("R10 no issue", 32'(unit_issue), 32'h0);
        wr_flag(1);
        check("R11 write 1 no effect", 32'(halt_all), 32'h1);
        wr_flag(0);
        check("R11 cleared", 32'(halt_all), 32'h0);

        wr_reg(32'h0000_1000);
        strobe(2'd3, 0, 0, 0);
        check("R3 step 32", reg_rd_data, 32'h0000_1020);
        strobe(2'd2, 0, 0, 0);
        check("R3 step 8", reg_rd_data, 32'h0000_1028);
        strobe(2'd0, 0, 0, 0);
        check("R3 step 2", reg_rd_data, 32'h0000_102A);
        strobe(2'd2, 0, 0, 0);
        check("R4 8B misaligned", 32'(halt_all), 32'h1);
        wr_flag(0);

        wr_reg(32'hE000_1000);
        strobe(2'd1, 1, 0, 0);
        check("R8 upper bits ignored", 32'(halt_all), 32'h0);
        check("R8 upper bits kept", reg_rd_data, 32'hE000_1004);

        wr_reg(32'h1C00_0000);
        strobe(2'd1, 1, 0, 0);
        check("R6 area7 external", 32'(halt_all), 32'h1);
        wr_flag(0);
        wr_reg(32'h1C00_0000);
        strobe(2'd1, 0, 0, 0);
        check("R6 area7 internal ok", 32'(halt_all), 32'h0);

        wr_reg(32'h1F20_0000);
        strobe(2'd1, 0, 0, 0);
        check("R7 window ok", 32'(halt_all), 32'h0);
        wr_reg(32'h1FC3_0000);
        strobe(2'd1, 0, 0, 0);
        check("R7 last window ok", 32'(halt_all), 32'h0);
        wr_reg(32'h1F10_0000);
        strobe(2'd1, 0, 0, 0);
        check("R7 hole rejected", 32'(halt_all), 32'h1);
        wr_flag(0);
        wr_reg(32'h1F81_0000);
        strobe(2'd1, 0, 0, 0);
        check("R7 past window rejected", 32'(halt_all), 32'h1);
        wr_flag(0);

        wr_reg(32'h0000_2003);
        strobe(2'd3, 0, 1, 1);
        check("R9 bypass issue", 32'(unit_issue), 32'h1);
        check("R9 no halt", 32'(halt_all), 32'h0);
        check("R9 no step", reg_rd_data, 32'h0000_2003);
        strobe(2'd3, 0, 1, 0);
        check("R9 sa without ack checked", 32'(halt_all), 32'h1);
        wr_flag(0);

        @(negedge clk); idle_inputs();
        reg_wr_en = 1; reg_wr_data = 32'h0000_3000; adv_strb = 1; xfer_size = 2'd1;
        @(negedge clk); idle_inputs();
        check("R2 write beats strobe", reg_rd_data, 32'h0000_3000);
        check("R2 strobe dropped", 32'(unit_issue), 32'h0);

        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            idle_inputs();
            adv_strb     = ($urandom % 3) != 0;
            xfer_size    = 2'($urandom);
            ext_bus      = 1'($urandom);
            sa_mode      = ($urandom % 4) == 0;
            dst_ack_dev  = 1'($urandom);
            flag_wr_en   = ($urandom % 4) == 0;
            flag_wr_data = ($urandom % 3) == 0;
            if (($urandom % 8) == 0) begin
                reg_wr_en   = 1;
                reg_wr_data = {$urandom} & (($urandom % 2) ? 32'hFFFF_FFE0 : 32'hFFFF_FFFF);
            end
        end
        @(negedge clk); idle_inputs();
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule